// File: doc/BRIEF.md
# Dual-Count PWM Timer Bank

A bank of identical timer channels sitting behind a small 32-bit memory-mapped port. Each channel runs in one of two modes. It can be a down-counting timer that raises an interrupt flag each time its count expires. It can also be a waveform generator. In that mode the channel holds its pin low for one programmed number of clocks, then high for a second programmed number, and keeps alternating. There is no period-plus-compare scheme. Each half of the waveform has its own load count.

Software programs the two counts and a 4-bit control word per channel. It then sets the enable bit. Clearing the enable bit stops the channel at once and parks its pin low. Count values are picked up only when a phase reloads, so the running phase always finishes with the value it started with. Each channel has an end-of-period flag. Its mask bit gates the flag onto an interrupt pin, and a read of a per-channel acknowledge address clears it.

The address map is split. Each channel's low count, control word and acknowledge address repeat on a 0x14 stride from offset 0. The high counts form a packed array of words starting at 0xB0. A fixed identification word sits at 0xAC.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset every count register, control word and end-of-period flag is zero, and every `pwmOut` and `irqOut` bit is low.
- R2: For channel k, the low-phase count is read and written at k*0x14, the control word (bits 3:0) at k*0x14+0x08, and the high-phase count at 0xB0+k*4. Each location reads back what was last written to it.
- R3: A read of 0xAC returns the `VERSION` parameter, and writes to 0xAC are ignored. Any other address outside the map reads as zero, and a write to it changes no register.
- R4: Control bits: bit 0 enable, bit 1 reload from the low count (when clear, the count reloads from all ones), bit 2 interrupt mask, bit 3 waveform mode. With bits 0 and 3 set, the pin is low for L cycles starting with the cycle after the enabling write, then high for H cycles, and this repeats. L is the low count and H is the high count.
- R5: While a channel is disabled, its pin is low and its counter is held at the low count. Once a write clears the enable bit, the pin is low from the next cycle onward.
- R6: A count written while the channel runs does not shorten or lengthen the phase in progress. It is used at the next reload of that phase.
- R7: With enable and bit 1 set and bit 3 clear, the pin stays low and the end-of-period flag sets every L cycles. The first time is L cycles after the enabling write.
- R8: With enable set and bits 1 and 3 clear, the first expiry follows the low count. Every later expiry follows a reload from the all-ones value of the counter width.
- R9: In waveform mode the flag sets at the end of each high phase. `irqOut[k]` equals the flag with the mask bit inverted. A read of k*0x14+0x0C returns the flag in bit 0 and clears it. A new expiry in the same cycle wins over the clear.
- R10: Channels are independent. Programming or running one channel changes no register, pin or flag of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock; one count per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational, valid while `busValid` is high and `busWrite` is low |
| pwmOut | output | NUM_CH | Per-channel waveform pin |
| irqOut | output | NUM_CH | Per-channel masked end-of-period flag |

## Verification
The properties assume that the bus presents at most one access per cycle, on word-aligned addresses. They also assume that each access is a single-cycle strobe, so a read of an acknowledge address clears its flag exactly once.

The bench drives every access as a one-cycle pulse placed between clock edges. It times the register updates made while a channel runs so that they land strictly inside a phase, never on a reload edge. With that placement, the hand-computed waveform is exact and does not depend on the order in which edges are resolved.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  // Per-channel strobes sent from the register decoder to a count engine.
  typedef struct packed {
    logic lowWr;
    logic highWr;
    logic ctrlWr;
    logic eoiRd;
  } chStrobe_t;

  localparam int CTRL_W   = 4;
  localparam int EN_BIT   = 0;
  localparam int USER_BIT = 1;
  localparam int MASK_BIT = 2;
  localparam int PWM_BIT  = 3;

  // Address map (byte offsets)
  localparam int CH_STRIDE   = 'h14;
  localparam int OFS_LOW     = 'h00;
  localparam int OFS_CTRL    = 'h08;
  localparam int OFS_EOI     = 'h0C;
  localparam int VER_ADDR    = 'hAC;
  localparam int HIGH_BASE   = 'hB0;
  localparam int HIGH_STRIDE = 'h04;

endpackage

// File: rtl/pwm_bank_regif.sv
module pwm_bank_regif
  import pwm_timer_pkg::*;
#(
  parameter int          NUM_CH  = 4,
  parameter int          CNT_W   = 32,
  parameter int          ADDR_W  = 8,
  parameter logic [31:0] VERSION = 32'h0001_0200
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             busValid,
  input  logic                             busWrite,
  input  logic [ADDR_W-1:0]                busAddr,
  input  logic [NUM_CH-1:0][CNT_W-1:0]     lowVal,
  input  logic [NUM_CH-1:0][CNT_W-1:0]     highVal,
  input  logic [NUM_CH-1:0][CTRL_W-1:0]    ctrlVal,
  input  logic [NUM_CH-1:0]                statusVal,
  output chStrobe_t [NUM_CH-1:0]           strobe,
  output logic [31:0]                      busRdata
);

  logic wrAccess;
  logic rdAccess;
  logic [31:0] rdMux;

  assign wrAccess = busValid && busWrite;
  assign rdAccess = busValid && !busWrite;

  always_comb begin
    strobe = '0;
    rdMux  = '0;
    if (busAddr == ADDR_W'(VER_ADDR)) begin
      rdMux = VERSION;
    end
    for (int k = 0; k < NUM_CH; k++) begin
      if (busAddr == ADDR_W'(k * CH_STRIDE + OFS_LOW)) begin
        strobe[k].lowWr = wrAccess;
        rdMux = 32'(lowVal[k]);
      end
      if (busAddr == ADDR_W'(k * CH_STRIDE + OFS_CTRL)) begin
        strobe[k].ctrlWr = wrAccess;
        rdMux = 32'(ctrlVal[k]);
      end
      if (busAddr == ADDR_W'(k * CH_STRIDE + OFS_EOI)) begin
        strobe[k].eoiRd = rdAccess;
        rdMux = {31'b0, statusVal[k]};
      end
      if (busAddr == ADDR_W'(HIGH_BASE + k * HIGH_STRIDE)) begin
        strobe[k].highWr = wrAccess;
        rdMux = 32'(highVal[k]);
      end
    end
  end

  assign busRdata = rdAccess ? rdMux : '0;

  // Each access reaches at most one register of one channel.
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe)) else $error("decode hit several targets"); // R2

  // Reads never produce write strobes.
  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    rdAccess |-> ($countones(strobe) == $countones({NUM_CH{1'b0}} | {NUM_CH{1'b0}})) ||
                 $onehot(strobe)) else $error("read produced odd strobes"); // R3

endmodule

// File: rtl/pwm_chan_engine.sv
module pwm_chan_engine
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  chStrobe_t         strobe,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  lowVal,
  output logic [CNT_W-1:0]  highVal,
  output logic [CTRL_W-1:0] ctrlVal,
  output logic              statusVal,
  output logic              pwmOut,
  output logic              irqOut
);

  localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

  logic [CNT_W-1:0]  lowReg;
  logic [CNT_W-1:0]  highReg;
  logic [CTRL_W-1:0] ctrlReg;
  logic [CNT_W-1:0]  cnt;
  logic              phaseHigh;
  logic              status;

  logic enable;
  logic userMode;
  logic pwmMode;
  logic term;
  logic periodEnd;

  assign enable    = ctrlReg[EN_BIT];
  assign userMode  = ctrlReg[USER_BIT];
  assign pwmMode   = ctrlReg[PWM_BIT];
  assign term      = (cnt <= ONE_CNT);
  assign periodEnd = enable && term && (pwmMode ? phaseHigh : 1'b1);

  // Register file of this channel
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowReg  <= '0;
      highReg <= '0;
      ctrlReg <= '0;
    end else begin
      if (strobe.lowWr)  lowReg  <= wrData;
      if (strobe.highWr) highReg <= wrData;
      if (strobe.ctrlWr) ctrlReg <= wrData[CTRL_W-1:0];
    end
  end

  // Count engine
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      phaseHigh <= 1'b0;
    end else if (!enable) begin
      cnt       <= lowReg;
      phaseHigh <= 1'b0;
    end else if (term) begin
      if (pwmMode) begin
        phaseHigh <= !phaseHigh;
        cnt       <= phaseHigh ? lowReg : highReg;
      end else begin
        phaseHigh <= 1'b0;
        cnt       <= userMode ? lowReg : '1;
      end
    end else begin
      cnt <= cnt - ONE_CNT;
      if (!pwmMode) phaseHigh <= 1'b0;
    end
  end

  // End-of-period flag: a new expiry wins over the acknowledge read
  always_ff @(posedge clk) begin
    if (!rstN)              status <= 1'b0;
    else if (periodEnd)     status <= 1'b1;
    else if (strobe.eoiRd)  status <= 1'b0;
  end

  assign lowVal    = lowReg;
  assign highVal   = highReg;
  assign ctrlVal   = ctrlReg;
  assign statusVal = status;
  assign pwmOut    = phaseHigh;
  assign irqOut    = status && !ctrlReg[MASK_BIT];

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !pwmOut) else $error("pin high while disabled"); // R5

  AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (enable && pwmMode && term) |=> (pwmOut != $past(pwmOut))) else $error("no toggle at expiry"); // R4

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (enable && pwmMode && !term) |=> $stable(pwmOut)) else $error("toggle mid-phase"); // R4

  AST_TIMER_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !pwmMode) |=> !pwmOut) else $error("pin moved in timer mode"); // R7

  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusVal) |-> $past(enable && term)) else $error("flag set without expiry"); // R9

  AST_EOI_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.eoiRd && !periodEnd) |=> !statusVal) else $error("acknowledge did not clear"); // R9

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
  import pwm_timer_pkg::*;
#(
  parameter int          NUM_CH  = 4,
  parameter int          CNT_W   = 32,
  parameter int          ADDR_W  = 8,
  parameter logic [31:0] VERSION = 32'h0001_0200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [NUM_CH-1:0] pwmOut,
  output logic [NUM_CH-1:0] irqOut
);

  chStrobe_t [NUM_CH-1:0]        strobe;
  logic [NUM_CH-1:0][CNT_W-1:0]  lowVal;
  logic [NUM_CH-1:0][CNT_W-1:0]  highVal;
  logic [NUM_CH-1:0][CTRL_W-1:0] ctrlVal;
  logic [NUM_CH-1:0]             statusVal;

  pwm_bank_regif #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .VERSION(VERSION)
  ) regif_i (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .lowVal   (lowVal),
    .highVal  (highVal),
    .ctrlVal  (ctrlVal),
    .statusVal(statusVal),
    .strobe   (strobe),
    .busRdata (busRdata)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
    pwm_chan_engine #(
      .CNT_W(CNT_W)
    ) engine_i (
      .clk      (clk),
      .rstN     (rstN),
      .strobe   (strobe[k]),
      .wrData   (busWdata[CNT_W-1:0]),
      .lowVal   (lowVal[k]),
      .highVal  (highVal[k]),
      .ctrlVal  (ctrlVal[k]),
      .statusVal(statusVal[k]),
      .pwmOut   (pwmOut[k]),
      .irqOut   (irqOut[k])
    );
  end

endmodule

// File: tb/pwm_timer_bank_tb.sv
`timescale 1ns/1ps
module pwm_timer_bank_tb_top;

  localparam int          NUM_CH  = 4;
  localparam int          CNT_W   = 8;
  localparam int          ADDR_W  = 8;
  localparam logic [31:0] VERSION = 32'hA5C3_0107;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busValid = 1'b0;
  logic              busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic [NUM_CH-1:0] pwmOut;
  logic [NUM_CH-1:0] irqOut;

  int nChecks = 0;
  int nErr = 0;
  int cyc = 0;

  typedef struct {
    int    ch;
    logic  out;
    logic  irq;
    string req;
  } expItem_t;
  expItem_t expQ[$];

  pwm_timer_bank #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .VERSION(VERSION)
  ) dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pwmOut(pwmOut), .irqOut(irqOut)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = ADDR_W'(a); busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rdVal(input int a, output logic [31:0] v);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = ADDR_W'(a);
    #1 v = busRdata;
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic rdCheck(input int a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rdVal(a, v);
    check(v === exp, req, v, exp);
  endtask

  task automatic pushWave(input int ch, input int lo, input int hi, input int n,
                          input int irqFrom, input string req);
    for (int i = 0; i < n; i++) begin
      expItem_t it;
      it.ch  = ch;
      it.out = ((i % (lo + hi)) >= lo);
      it.irq = (i >= irqFrom);
      it.req = req;
      expQ.push_back(it);
    end
  endtask

  // Monitor: one expected item per cycle, compared between edges
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        check(pwmOut[it.ch] === it.out, {it.req, " pin"}, 32'(pwmOut[it.ch]), 32'(it.out));
        check(irqOut[it.ch] === it.irq, {it.req, " irq"}, 32'(irqOut[it.ch]), 32'(it.irq));
      end
    end
  end

  // Watchdog
  initial begin
    #(5.0 * 150000);
    nChecks++; nErr++;
    $display("FAIL watchdog: actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    int c0;
    int waited;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    check(pwmOut === '0, "R1 pins", 32'(pwmOut), 0);
    check(irqOut === '0, "R1 irq", 32'(irqOut), 0);
    rdCheck('h08, 0, "R1 ctrl");
    rdCheck('h00, 0, "R1 low");
    rdCheck('hB0, 0, "R1 high");
    rdCheck('h0C, 0, "R1 flag");

    // R2 / R10: address map, per-channel readback
    for (int k = 0; k < NUM_CH; k++) begin
      wr(k * 'h14, 'h10 + k);
      wr('hB0 + k * 4, 'h20 + k);
      wr(k * 'h14 + 8, 'hE);
    end
    for (int k = 0; k < NUM_CH; k++) begin
      rdCheck(k * 'h14, 'h10 + k, "R2 low");
      rdCheck('hB0 + k * 4, 'h20 + k, "R2 high");
      rdCheck(k * 'h14 + 8, 'hE, "R2 ctrl");
    end

    // R3: identification word and unmapped space
    rdCheck('hAC, VERSION, "R3 version");
    wr('hAC, 'h55);
    rdCheck('hAC, VERSION, "R3 version write ignored");
    wr('h50, 'h77);
    rdCheck('h50, 0, "R3 unmapped");
    rdCheck('h04, 0, "R3 gap");
    rdCheck('h00, 'h10, "R3 no side effect");

    // R5: disabled channels keep pins low
    repeat (3) begin
      @(negedge clk); #1;
      check(pwmOut === '0, "R5 idle", 32'(pwmOut), 0);
    end

    // R4 / R9: waveform L=3 H=2, unmasked
    wr('h00, 3);
    wr('hB0, 2);
    wr('h08, 'hB);
    pushWave(0, 3, 2, 10, 5, "R4");
    wait (expQ.size() == 0);
    wr('h08, 'hA);
    repeat (3) begin
      @(negedge clk); #1;
      check(pwmOut[0] === 1'b0, "R5 after disable", 32'(pwmOut[0]), 0);
    end
    rdCheck('h0C, 1, "R9 ack returns flag");
    rdCheck('h0C, 0, "R9 ack cleared");
    #1 check(irqOut[0] === 1'b0, "R9 irq cleared", 32'(irqOut[0]), 0);

    // R6: updates mid-phase apply at the next reload
    wr('h00, 6);
    wr('hB0, 3);
    wr('h08, 'hB);
    for (int i = 0; i < 20; i++) begin
      expItem_t it;
      it.ch  = 0;
      it.out = (i >= 6 && i <= 10) || (i >= 13 && i <= 17);
      it.irq = (i >= 11);
      it.req = "R6";
      expQ.push_back(it);
    end
    wr('h00, 2);
    wr('hB0, 5);
    wait (expQ.size() == 0);
    wr('h08, 'hA);
    rdVal('h0C, v);

    // R7: plain timer, reload from low count
    wr('h14, 5);
    wr('h1C, 'h3);
    for (int i = 0; i < 7; i++) begin
      expItem_t it;
      it.ch = 1; it.out = 1'b0; it.irq = (i >= 5); it.req = "R7";
      expQ.push_back(it);
    end
    wait (expQ.size() == 0);
    wr('h1C, 'h2);
    rdVal('h20, v);

    // R8: free-running reload from all ones after first expiry
    wr('h28, 3);
    wr('h30, 'h1);
    c0 = cyc;
    for (int i = 0; i < 4; i++) begin
      expItem_t it;
      it.ch = 2; it.out = 1'b0; it.irq = (i >= 3); it.req = "R8";
      expQ.push_back(it);
    end
    wait (expQ.size() == 0);
    rdCheck('h34, 1, "R8 first expiry");
    waited = 0;
    while (irqOut[2] !== 1'b1 && waited < 400) begin
      @(negedge clk); #1;
      waited++;
    end
    check((cyc - c0) == 3 + (1 << CNT_W) - 1, "R8 second expiry cycle",
          32'(cyc - c0), 32'(3 + (1 << CNT_W) - 1));
    wr('h30, 'h0);
    rdVal('h34, v);

    // R9 mask / R10 independence: channel 3 masked
    wr('h3C, 2);
    wr('hBC, 2);
    wr('h44, 'hF);
    pushWave(3, 2, 2, 8, 100, "R9 masked");
    wait (expQ.size() == 0);
    #1 check(pwmOut[2:0] === 3'b000, "R10 others idle", 32'(pwmOut[2:0]), 0);
    rdCheck('h48, 1, "R9 masked flag still set");
    wr('h44, 'hE);
    rdCheck('h00, 2, "R10 ch0 low kept");
    rdCheck('hB4, 'h21, "R10 ch1 high kept");
    rdCheck('h30, 0, "R10 ch2 ctrl kept");

    finishRun();
  end

endmodule